// File: doc/BRIEF.md
# Multi-Pulse Reset Release Sequencer

This block owns the active-low reset pin of an attached security chip. A host sends single-cycle strobes: one to hold the chip in reset and one to let it out. Letting it out is not a single edge. The chip must see three long deasserted waits with two short assert pulses between them. Without that pattern it takes the reset activity as an attack and enters a protective mode. The block walks this pattern on its own. It raises `busy` while the pattern runs and raises `ready` once the last long wait has fully passed, which is the point where the first command may be sent to the chip.

Both interval lengths come from a clock-frequency parameter and a time parameter for each interval. The cycle count is always rounded up, so no interval is shorter than its minimum. Small values can be set for simulation. A hold strobe takes priority at all times: it stops any sequence in progress and forces the pin low.

Top module: `rst_release_seq`

## Requirements
- R1: After synchronous reset, `chip_rst_n` is 0, `busy` is 0 and `ready` is 0.
- R2: The pin is active-low. Logical "asserted" drives `chip_rst_n` to 0 and "deasserted" drives it to 1.
- R3: A release strobe is accepted when the block is holding or ready and `hold_req` is low. In the cycle after an accepted strobe, `chip_rst_n` is 1, `busy` is 1 and `ready` is 0.
- R4: Each long deasserted interval lasts exactly LONG = ceil(CLK_FREQ_HZ × LONG_WAIT_US / 10^6) clock cycles.
- R5: Each long interval except the last is followed by an asserted pulse of exactly SHORT = ceil(CLK_FREQ_HZ × SHORT_PULSE_NS / 10^9) cycles. The pattern is long, short, long, short, long, so there are exactly two pulses.
- R6: `ready` rises, and `busy` falls, exactly 3×LONG + 2×SHORT cycles after the edge that accepted the release strobe. After that the pin stays at 1.
- R7: A hold strobe drives `chip_rst_n` to 0 and clears `busy` and `ready` in the next cycle, in any state, and aborts any running sequence. If both strobes arrive in the same cycle, the hold strobe wins.
- R8: A release strobe that arrives while `busy` is 1 is ignored. The running sequence keeps its original timing.
- R9: A release strobe that arrives while `ready` is 1 clears `ready` and restarts the full sequence from its first long interval.
- R10: After a hold, the pin stays at 0 with `busy` and `ready` low until a release strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_FREQ_HZ |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Strobe: put the chip in reset and keep it there |
| release_req | input | 1 | Strobe: run the release pattern |
| chip_rst_n | output | 1 | Active-low reset pin to the chip |
| busy | output | 1 | Release pattern in progress |
| ready | output | 1 | Chip may accept its first command |

## Verification
All three outputs are registered. A strobe sampled at one rising edge therefore shows its effect right after that same edge. Every later phase change falls on an edge a fixed number of cycles away: LONG, LONG+SHORT, 2·LONG+SHORT, 2·LONG+2·SHORT and 3·LONG+2·SHORT, counted from the accepting edge. The bench counts edges from the accepting edge, and a quarter period after every edge it compares all three outputs against the phase that this count implies. Because every cycle is checked, an interval that is off by a single cycle shows up at its boundary. Holds and repeated releases are swept across every offset of the pattern.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    PH_HOLD   = 3'd0,
    PH_WAIT1  = 3'd1,
    PH_PULSE1 = 3'd2,
    PH_WAIT2  = 3'd3,
    PH_PULSE2 = 3'd4,
    PH_WAIT3  = 3'd5,
    PH_READY  = 3'd6
  } rrs_phase_e;
endpackage

// File: rtl/rrs_timer.sv
module rrs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // The counter must rest at zero and never wrap around.
  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);  // R4
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LONG_CYC  = 4,
  parameter int SHORT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_req,
  input  logic             release_req,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             chip_rst_n,
  output logic             busy,
  output logic             ready
);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);

  rrs_phase_e phase, nxt;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = LONG_LD;
    if (hold_req) begin
      nxt = PH_HOLD;
    end else if (release_req && (phase == PH_HOLD || phase == PH_READY)) begin
      nxt  = PH_WAIT1;
      load = 1'b1;
    end else if (expired) begin
      unique case (phase)
        PH_WAIT1:  begin nxt = PH_PULSE1; load = 1'b1; load_val = SHORT_LD; end
        PH_PULSE1: begin nxt = PH_WAIT2;  load = 1'b1; end
        PH_WAIT2:  begin nxt = PH_PULSE2; load = 1'b1; load_val = SHORT_LD; end
        PH_PULSE2: begin nxt = PH_WAIT3;  load = 1'b1; end
        PH_WAIT3:  nxt = PH_READY;
        default:   nxt = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_HOLD;
      chip_rst_n <= 1'b0;
      busy       <= 1'b0;
      ready      <= 1'b0;
    end else begin
      phase      <= nxt;
      chip_rst_n <= !(nxt == PH_HOLD || nxt == PH_PULSE1 || nxt == PH_PULSE2);
      busy       <= !(nxt == PH_HOLD || nxt == PH_READY);
      ready      <= (nxt == PH_READY);
    end
  end

  AST_HOLD_WINS: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> (!chip_rst_n && !busy && !ready));  // R7
  AST_START_SEQ: assert property (@(posedge clk) disable iff (rst)
    (release_req && !hold_req && !busy) |=> (busy && chip_rst_n && !ready));  // R3
  AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && ready));  // R6
  AST_READY_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ready |-> chip_rst_n);  // R6
  AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(busy));  // R6
  AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ready) |-> !chip_rst_n);  // R10
  AST_PULSE_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(chip_rst_n) && busy) |-> $past(busy));  // R5
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq #(
  parameter int CLK_FREQ_HZ    = 50_000_000,
  parameter int LONG_WAIT_US   = 60_000,
  parameter int SHORT_PULSE_NS = 2_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic release_req,
  output logic chip_rst_n,
  output logic busy,
  output logic ready
);
  // Round up so that no interval is ever shorter than its minimum.
  localparam longint LONG_L  = (longint'(CLK_FREQ_HZ) * longint'(LONG_WAIT_US) + 64'd999_999) / 64'd1_000_000;
  localparam longint SHORT_L = (longint'(CLK_FREQ_HZ) * longint'(SHORT_PULSE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int LONG_CYC  = (LONG_L  < 1) ? 1 : int'(LONG_L);
  localparam int SHORT_CYC = (SHORT_L < 1) ? 1 : int'(SHORT_L);
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  rrs_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  rrs_ctrl #(
    .CNT_W     (CNT_W),
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .hold_req    (hold_req),
    .release_req (release_req),
    .expired     (tmr_expired),
    .load        (tmr_load),
    .load_val    (tmr_val),
    .chip_rst_n  (chip_rst_n),
    .busy        (busy),
    .ready       (ready)
  );
endmodule

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int LW_US  = 17;
  localparam int SP_NS  = 2_500;
  // ceil(1e6*17/1e6)=17, ceil(1e6*2500/1e9)=3 (exercises rounding up)
  localparam int L = (CLK_HZ * LW_US + 999_999) / 1_000_000;
  localparam int S = int'((longint'(CLK_HZ) * SP_NS + 999_999_999) / 1_000_000_000);
  localparam int T = 3 * L + 2 * S;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0;
  logic release_req = 1'b0;
  logic chip_rst_n, busy, ready;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int held  = 1;
  int start = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  rst_release_seq #(
    .CLK_FREQ_HZ    (CLK_HZ),
    .LONG_WAIT_US   (LW_US),
    .SHORT_PULSE_NS (SP_NS)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .hold_req    (hold_req),
    .release_req (release_req),
    .chip_rst_n  (chip_rst_n),
    .busy        (busy),
    .ready       (ready)
  );

  task automatic check3(input bit ep, input bit eb, input bit er, input string tag);
    n_vec++;
    if (chip_rst_n !== ep || busy !== eb || ready !== er) begin
      n_fail++;
      $display("FAIL %s cyc=%0d: pin/busy/ready=%b%b%b expected %b%b%b",
               tag, cyc, chip_rst_n, busy, ready, ep, eb, er);
    end
  endtask

  // One clock edge with the given strobes; expected outputs from the requirement model.
  task automatic step(input bit h, input bit r);
    int d;
    bit ep, eb, er;
    string tag;
    @(negedge clk);
    hold_req    = h;
    release_req = r;
    // R8/R9: release accepted only when holding or ready (pre-edge state)
    if (!h && r && (held != 0 || (cyc - start) >= T)) begin
      held  = 0;
      start = cyc + 1;
    end
    if (h) held = 1;
    cyc++;
    @(posedge clk);
    #5;
    if (held != 0) begin
      ep = 0; eb = 0; er = 0; tag = h ? "R7" : "R10";
    end else begin
      d  = cyc - start;
      eb = (d < T);
      er = (d >= T);
      if (d < L)                  begin ep = 1; tag = (d == 0) ? "R3" : "R4"; end
      else if (d < L + S)         begin ep = 0; tag = "R5"; end
      else if (d < 2 * L + S)     begin ep = 1; tag = "R4"; end
      else if (d < 2 * L + 2 * S) begin ep = 0; tag = "R5"; end
      else if (d < T)             begin ep = 1; tag = "R4"; end
      else                        begin ep = 1; tag = "R6"; end
      if (r && d > 0) tag = (d < T) ? "R8" : tag;
      if (r && d == 0 && cyc > 1) tag = "R9";
    end
    check3(ep, eb, er, tag);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check3(1'b0, 1'b0, 1'b0, "R1");  // R1 reset state, R2 pin low = asserted
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    check3(1'b0, 1'b0, 1'b0, "R1");

    // R10: stays held without release
    repeat (4) step(0, 0);
    // R3 R4 R5 R6: full pattern from hold
    step(0, 1);
    repeat (T + 4) step(0, 0);
    // R9: restart from ready
    step(0, 1);
    repeat (T + 3) step(0, 0);
    // R7: hold while ready
    step(1, 0);
    repeat (3) step(0, 0);
    // R8: release held high through a whole run; restarts once ready (R9)
    step(0, 1);
    repeat (T + 3) step(0, 1);
    repeat (2) step(0, 0);
    step(1, 0);
    // R7: hold and release together while holding, hold wins
    step(1, 1);
    step(0, 0);
    // R7 R10: abort at every offset of the pattern
    for (int h = 1; h <= T + 1; h++) begin
      step(0, 1);
      for (int k = 1; k < h; k++) step(0, 0);
      step(1, 0);
      step(0, 0);
      step(0, 0);
    end
    // R8: single release strobes at each offset of a run are ignored
    for (int o = 1; o < T; o += 5) begin
      step(0, 1);
      for (int k = 1; k < o; k++) step(0, 0);
      step(0, 1);
      for (int k = o + 1; k <= T + 1; k++) step(0, 0);
      step(1, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule